// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces effective addresses for pointers that step around a circular region of data memory. Two address paths share one buffer description: a read path and a write path. Each path takes a pointer and a signed offset, adds them, and folds the sum back into the buffer when it leaves through the boundary that the buffer's alignment selects. The buffer is described by a start byte address and an end byte address. Both are loaded through a small write port. Address generation itself is combinational.

When the configuration is loaded, the buffer is classified into one of four modes. That classification is held in an enumerated state register. Let the length L be end - start + 1, and let the mask be every bit up to and including the highest set bit of L - 1. The buffer is aligned low when start AND mask equals 0. It is aligned high when end AND mask equals mask. The states are:

- `MODE_NONE`: neither alignment holds, or end < start.
- `MODE_UP`: only aligned low.
- `MODE_DOWN`: only aligned high.
- `MODE_BOTH`: both alignments hold.

At reset the state is `MODE_NONE`. On every configuration write there is exactly one transition, "reclassify". It moves from any state to the state that the newly written start/end pair selects. Without a write the state holds.

The write path has a bit-reverse flag. While that flag is high, the write path performs no folding. The read path keeps folding as usual.

Top module: `cbag_top`

## Requirements
- R1: After reset, start and end are 0 and the state is `MODE_NONE`, so each output equals pointer + offset.
- R2: In `MODE_UP` or `MODE_BOTH`, with enable high, a sum S greater than end produces start + (S - end - 1).
- R3: In `MODE_UP`, a sum below start is output unchanged.
- R4: In `MODE_DOWN` or `MODE_BOTH`, with enable high, a sum S below start produces end - (start - S - 1).
- R5: In `MODE_DOWN`, a sum above end is output unchanged.
- R6: `MODE_BOTH` arises only when L is a power of two, and it folds at both boundaries.
- R7: In `MODE_NONE`, no sum is folded.
- R8: With enable low, both outputs equal pointer + offset, whatever the state.
- R9: With the write path's bit-reverse flag high, the write output equals pointer + offset. The read output keeps folding in the same cycle.
- R10: A sum inside [start, end] is output unchanged.
- R11: A configuration write selects start (select 0) or end (select 1). It takes effect at the next rising clock edge. Without a write, the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 writes start, 1 writes end |
| cfg_wdata | input | 16 | Configuration write data |
| mod_en | input | 1 | Enables folding on both paths |
| wr_rev_mode | input | 1 | Bit-reverse active on the write path; suppresses its folding |
| rd_ptr | input | 16 | Read-path pointer |
| rd_off | input | 16 | Read-path signed offset |
| wr_ptr | input | 16 | Write-path pointer |
| wr_off | input | 16 | Write-path signed offset |
| rd_ea | output | 16 | Read-path effective address |
| wr_ea | output | 16 | Write-path effective address |

## Verification
The folding assertions assume that no step crosses a boundary by more than L bytes. They also assume that pointer + offset never wraps past 0 or 0xFFFF, because a fold is only guaranteed to land inside the buffer under those conditions. The directed stimulus keeps every pointer and offset within these limits. All buffers are placed near 0x1000, and offsets stay at a few bytes. The check that the state holds assumes configuration writes arrive only as single strobed cycles, and the bench drives them that way.

// File: rtl/cbag_pkg.sv
package cbag_pkg;

    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_UP   = 2'd1,
        MODE_DOWN = 2'd2,
        MODE_BOTH = 2'd3
    } cbag_mode_e;

    // Sets every bit at or below the highest set bit of v.
    function automatic logic [15:0] smear16(input logic [15:0] v);
        logic [15:0] m;
        m = v;
        for (int i = 1; i < 16; i = i * 2) begin
            m = m | (m >> i);
        end
        return m;
    endfunction

endpackage

// File: rtl/cbag_cfg.sv
module cbag_cfg
    import cbag_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] buf_start,
    output logic [AW-1:0] buf_end,
    output cbag_mode_e    mode
);
    localparam int LW = AW + 1;

    logic [AW-1:0] start_nx, end_nx;
    logic [LW-1:0] len_nx;
    logic [AW-1:0] mask_nx;
    logic          lo_ok, hi_ok;
    cbag_mode_e    mode_nx;

    always_comb begin
        start_nx = buf_start;
        end_nx   = buf_end;
        if (cfg_we) begin
            if (cfg_sel) end_nx   = cfg_wdata;
            else         start_nx = cfg_wdata;
        end
    end

    always_comb begin
        len_nx  = {1'b0, end_nx} - {1'b0, start_nx} + LW'(1);
        mask_nx = AW'(smear16(16'(end_nx - start_nx)));
        lo_ok   = (start_nx & mask_nx) == '0;
        hi_ok   = (end_nx & mask_nx) == mask_nx;
    end

    // Reclassify: every write chooses the next state from the new pair.
    always_comb begin
        mode_nx = mode;
        if (cfg_we) begin
            unique case ({lo_ok, hi_ok})
                2'b11:   mode_nx = MODE_BOTH;
                2'b10:   mode_nx = MODE_UP;
                2'b01:   mode_nx = MODE_DOWN;
                default: mode_nx = MODE_NONE;
            endcase
            if (end_nx < start_nx) mode_nx = MODE_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_NONE;
        end else begin
            mode <= mode_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_start <= '0;
            buf_end   <= '0;
        end else begin
            buf_start <= start_nx;
            buf_end   <= end_nx;
        end
    end

    logic [LW-1:0] len_q;
    assign len_q = {1'b0, buf_end} - {1'b0, buf_start} + LW'(1);

    // R6: two-sided folding only for power-of-two lengths
    assert_both_pow2_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BOTH) |-> ($countones(len_q) == 1));

    // R11: state holds without a write
    assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(mode));

endmodule

// File: rtl/cbag_path.sv
module cbag_path
    import cbag_pkg::*;
#(
    parameter int AW      = 16,
    parameter int OW      = 16,
    parameter bit REG_OUT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 bypass,
    input  cbag_mode_e           mode,
    input  logic [AW-1:0]        buf_start,
    input  logic [AW-1:0]        buf_end,
    input  logic [AW-1:0]        ptr,
    input  logic signed [OW-1:0] off,
    output logic [AW-1:0]        ea
);
    localparam int LW = AW + 1;

    logic [AW-1:0] sum;
    logic          chk_hi, chk_lo, fold_hi, fold_lo;
    logic [AW-1:0] ea_c;

    always_comb begin
        sum    = ptr + AW'(off);
        chk_hi = en && !bypass && (mode == MODE_UP   || mode == MODE_BOTH);
        chk_lo = en && !bypass && (mode == MODE_DOWN || mode == MODE_BOTH);
        fold_hi = chk_hi && (sum > buf_end);
        fold_lo = chk_lo && (sum < buf_start);
    end

    always_comb begin
        if (fold_hi)      ea_c = buf_start + (sum - buf_end - AW'(1));
        else if (fold_lo) ea_c = buf_end - (buf_start - sum - AW'(1));
        else              ea_c = sum;
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) ea <= '0;
                else        ea <= ea_c;
            end
        end else begin : g_comb
            assign ea = ea_c;

            logic [LW-1:0] len;
            assign len = {1'b0, buf_end} - {1'b0, buf_start} + LW'(1);

            // R2: an upper fold of at most one length lands inside the buffer
            assert_hi_inside_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (chk_hi && sum > buf_end && ({1'b0, sum} - {1'b0, buf_end}) <= len)
                |-> (ea >= buf_start && ea <= buf_end));

            // R4: a lower fold of at most one length lands inside the buffer
            assert_lo_inside_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (chk_lo && sum < buf_start && ({1'b0, buf_start} - {1'b0, sum}) <= len)
                |-> (ea >= buf_start && ea <= buf_end));
        end
    endgenerate

endmodule

// File: rtl/cbag_top.sv
module cbag_top
    import cbag_pkg::*;
#(
    parameter int AW      = 16,
    parameter int OW      = 16,
    parameter bit REG_OUT = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cfg_sel,
    input  logic [AW-1:0]        cfg_wdata,
    input  logic                 mod_en,
    input  logic                 wr_rev_mode,
    input  logic [AW-1:0]        rd_ptr,
    input  logic signed [OW-1:0] rd_off,
    input  logic [AW-1:0]        wr_ptr,
    input  logic signed [OW-1:0] wr_off,
    output logic [AW-1:0]        rd_ea,
    output logic [AW-1:0]        wr_ea
);
    localparam int NP = 2;

    logic [AW-1:0] buf_start, buf_end;
    cbag_mode_e    mode;

    logic [AW-1:0]        p_ptr [NP];
    logic signed [OW-1:0] p_off [NP];
    logic                 p_byp [NP];
    logic [AW-1:0]        p_ea  [NP];

    assign p_ptr[0] = rd_ptr;
    assign p_off[0] = rd_off;
    assign p_byp[0] = 1'b0;
    assign p_ptr[1] = wr_ptr;
    assign p_off[1] = wr_off;
    assign p_byp[1] = wr_rev_mode;
    assign rd_ea    = p_ea[0];
    assign wr_ea    = p_ea[1];

    cbag_cfg #(.AW(AW)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .buf_start (buf_start),
        .buf_end   (buf_end),
        .mode      (mode)
    );

    generate
        for (genvar g = 0; g < NP; g++) begin : g_path
            cbag_path #(.AW(AW), .OW(OW), .REG_OUT(REG_OUT)) u_path (
                .clk       (clk),
                .rst_n     (rst_n),
                .en        (mod_en),
                .bypass    (p_byp[g]),
                .mode      (mode),
                .buf_start (buf_start),
                .buf_end   (buf_end),
                .ptr       (p_ptr[g]),
                .off       (p_off[g]),
                .ea        (p_ea[g])
            );
        end
    endgenerate

endmodule

// File: tb/cbag_top_test.sv
module cbag_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic        mod_en = 1'b1;
    logic        wr_rev_mode = 1'b0;
    logic [15:0] rd_ptr = '0;
    logic signed [15:0] rd_off = '0;
    logic [15:0] wr_ptr = '0;
    logic signed [15:0] wr_off = '0;
    logic [15:0] rd_ea, wr_ea;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cbag_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .mod_en(mod_en), .wr_rev_mode(wr_rev_mode),
        .rd_ptr(rd_ptr), .rd_off(rd_off), .wr_ptr(wr_ptr), .wr_off(wr_off),
        .rd_ea(rd_ea), .wr_ea(wr_ea)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic sel, input logic [15:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_buf(input logic [15:0] s, input logic [15:0] e);
        cfg_write(1'b0, s);
        cfg_write(1'b1, e);
    endtask

    task automatic apply(input logic [15:0] rp, input logic [15:0] ro,
                         input logic [15:0] wp, input logic [15:0] wo);
        rd_ptr = rp; rd_off = ro; wr_ptr = wp; wr_off = wo;
        #1;
    endtask

    task automatic t_reset;
        apply(16'h1000, 16'h0008, 16'h2000, 16'hFFFC);
        check("R1 reset rd", rd_ea, 16'h1008);
        check("R1 reset wr", wr_ea, 16'h1FFC);
    endtask

    task automatic t_up;
        set_buf(16'h1000, 16'h1017);
        apply(16'h1014, 16'h0006, 16'h1004, 16'h0002);
        check("R2 up fold rd", rd_ea, 16'h1002);
        check("R10 inside wr", wr_ea, 16'h1006);
        apply(16'h1002, 16'hFFFC, 16'h1017, 16'h0001);
        check("R3 up below start", rd_ea, 16'h0FFE);
        check("R2 up fold at end+1", wr_ea, 16'h1000);
    endtask

    task automatic t_down;
        set_buf(16'h1008, 16'h101F);
        apply(16'h100A, 16'hFFFC, 16'h101E, 16'h0004);
        check("R4 down fold rd", rd_ea, 16'h101E);
        check("R5 down above end", wr_ea, 16'h1022);
    endtask

    task automatic t_both;
        set_buf(16'h1000, 16'h101F);
        apply(16'h101E, 16'h0004, 16'h1002, 16'hFFFC);
        check("R6 both upper rd", rd_ea, 16'h1002);
        check("R6 both lower wr", wr_ea, 16'h101E);
    endtask

    task automatic t_none;
        set_buf(16'h1004, 16'h1013);
        apply(16'h1012, 16'h0004, 16'h1006, 16'hFFFC);
        check("R7 none above", rd_ea, 16'h1016);
        check("R7 none below", wr_ea, 16'h1002);
    endtask

    task automatic t_disable;
        set_buf(16'h1000, 16'h101F);
        mod_en = 1'b0;
        apply(16'h101E, 16'h0004, 16'h1002, 16'hFFFC);
        check("R8 disabled rd", rd_ea, 16'h1022);
        check("R8 disabled wr", wr_ea, 16'h0FFE);
        mod_en = 1'b1;
    endtask

    task automatic t_rev;
        wr_rev_mode = 1'b1;
        apply(16'h101E, 16'h0004, 16'h101E, 16'h0004);
        check("R9 rev rd still folds", rd_ea, 16'h1002);
        check("R9 rev wr unfolded", wr_ea, 16'h1022);
        wr_rev_mode = 1'b0;
        #1;
        check("R9 rev cleared wr folds", wr_ea, 16'h1002);
    endtask

    task automatic t_timing;
        apply(16'h101E, 16'h0004, 16'h1010, 16'h0001);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b1; cfg_wdata = 16'h1017;
        #1;
        check("R11 before edge old cfg", rd_ea, 16'h1002);
        @(negedge clk);
        cfg_we = 1'b0;
        #1;
        check("R11 after edge new cfg", rd_ea, 16'h100A);
        repeat (3) @(negedge clk);
        #1;
        check("R11 holds w/o write", rd_ea, 16'h100A);
        check("R10 inside after update", wr_ea, 16'h1011);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset;
        rst_n = 1'b1;
        t_up;
        t_down;
        t_both;
        t_none;
        t_disable;
        t_rev;
        t_timing;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule